// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the address for each beat of a four-beat burst. When either of two address strobes is high at a clock edge, it captures the full external address. The captured low two bits become the starting offset, and a two-bit beat count is cleared. After that, each clock edge with the active-low advance input low moves the burst to its next beat. When the advance input is high, the cycle is a wait cycle and the address does not change. The upper address bits keep the captured value for the whole burst.

A static mode input picks the beat order:

- **Linear (mode = 0):** the offset is the starting offset plus the beat count, modulo 4.
- **Interleaved (mode = 1):** the offset is the starting offset XOR the beat count.

After four advances, both orders wrap back to the starting offset. The mode input is decoded combinationally, so it takes effect at once on the current beat.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the base register and beat count clear. `addr_o` reads 0 after that edge, even in the middle of a burst.
- R2: A clock edge with `ld_a_i` or `ld_b_i` high captures `addr_i`. After that edge, `addr_o` equals the captured address exactly.
- R3: Between loads, `addr_o[ADDR_W-1:2]` holds the captured upper bits. Changes on `addr_i` have no effect when no strobe is high.
- R4: With `ilv_mode_i` = 0 (linear), each advance adds 1 modulo 4 to `addr_o[1:0]`. Starting at 01 the order is 01, 10, 11, 00; starting at 10 it is 10, 11, 00, 01.
- R5: With `ilv_mode_i` = 1 (interleaved), `addr_o[1:0]` is the start offset XOR the beat count. Starting at 10 the order is 10, 11, 00, 01; starting at 11 it is 11, 10, 01, 00.
- R6: A clock edge with `adv_n_i` high and no strobe is a wait cycle. `addr_o` is unchanged after it.
- R7: After four advances, the offset returns to the starting offset, and the burst continues from there without error.
- R8: If a strobe and an advance occur at the same edge, the load wins. `addr_o` then equals `addr_i`, with the beat count at zero.
- R9: Changing `ilv_mode_i` in the middle of a burst re-maps the current beat at once. For example, start 01 with count 1 gives 00 when interleaved and 10 when linear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_a_i | input | 1 | First address strobe, active high |
| ld_b_i | input | 1 | Second address strobe, active high |
| adv_n_i | input | 1 | Beat advance, active low; high means wait |
| ilv_mode_i | input | 1 | Static order select: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External address captured on a strobe |
| addr_o | output | ADDR_W | Current beat address |

## Verification
The assertions check on every cycle that a strobe makes the captured address visible. They also check that a wait cycle leaves the address alone and that the upper bits never move between loads. In linear mode, they check that each advance adds exactly one to the offset, and that a load clears the beat count even when an advance occurs at the same edge. Only the bench's scenarios can show the following:

- the complete interleaved orders from each starting offset;
- the wrap back to the start after four advances;
- the immediate re-mapping when the mode input changes;
- reset in the middle of a burst.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Four beats per burst: two offset bits generated internally.
    localparam int OFS_W = 2;

    typedef logic [OFS_W-1:0] ofs_t;

    typedef enum logic {
        SEQ_LINEAR = 1'b0,
        SEQ_XOR    = 1'b1
    } seq_mode_e;

    typedef struct packed {
        ofs_t start;
        ofs_t count;
    } beat_state_t;

    // Map a start offset and a running beat count onto the bus offset.
    function automatic ofs_t map_offset(seq_mode_e m, ofs_t s, ofs_t c);
        ofs_t r;
        if (m == SEQ_XOR) begin
            r = s ^ c;
        end else begin
            r = ofs_t'(s + c);
        end
        return r;
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
#(
    parameter int CNT_W = OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reload,
    input  logic             step,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (reload) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

    // R8: a reload clears the count even when a step arrives with it
    a_r8_reload_clears: assert property (@(posedge clk) disable iff (rst)
        reload |=> (count == '0));

    // R7: the last beat wraps to zero on a step
    a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (step && !reload && count == CNT_LAST) |=> (count == '0));

    // R6: no step and no reload leaves the count alone
    a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !reload) |=> $stable(count));

endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LOW_W  = OFS_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic [ADDR_W-LOW_W-1:0] upper,
    output logic [LOW_W-1:0]        start
);

    localparam int UP_W = ADDR_W - LOW_W;

    logic [UP_W-1:0]  upper_q;
    logic [LOW_W-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q <= '0;
            start_q <= '0;
        end else if (load) begin
            upper_q <= addr_i[ADDR_W-1:LOW_W];
            start_q <= addr_i[LOW_W-1:0];
        end
    end

    assign upper = upper_q;
    assign start = start_q;

    // R3: captured address is held between loads
    a_r3_base_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(upper) && $stable(start)));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  seq_mode_e mode,
    input  ofs_t      start,
    input  ofs_t      count,
    output ofs_t      offset
);

    beat_state_t st;

    always_comb begin
        st.start = start;
        st.count = count;
        offset   = map_offset(mode, st.start, st.count);
    end

    // R2: the first beat of either order is the start offset
    always_comb begin
        if (count == '0) begin
            a_r2_first_beat: assert (offset == start);
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_a_i,
    input  logic              ld_b_i,
    input  logic              adv_n_i,
    input  logic              ilv_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int UP_W = ADDR_W - OFS_W;

    logic            load;
    logic            step;
    seq_mode_e       mode;
    logic [UP_W-1:0] upper;
    ofs_t            start;
    ofs_t            count;
    ofs_t            offset;

    assign load = ld_a_i | ld_b_i;
    assign step = ~adv_n_i;
    assign mode = seq_mode_e'(ilv_mode_i);

    burst_base_reg #(
        .ADDR_W (ADDR_W),
        .LOW_W  (OFS_W)
    ) u_base (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .addr_i (addr_i),
        .upper  (upper),
        .start  (start)
    );

    burst_beat_ctr #(
        .CNT_W (OFS_W)
    ) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .reload (load),
        .step   (step),
        .count  (count)
    );

    burst_order_map u_map (
        .mode   (mode),
        .start  (start),
        .count  (count),
        .offset (offset)
    );

    assign addr_o = {upper, offset};

    // R2: a strobe makes the external address visible after the edge
    a_r2_load_visible: assert property (@(posedge clk) disable iff (rst)
        load |=> (addr_o == $past(addr_i)));

    // R3: upper bits never move without a strobe
    a_r3_upper_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(addr_o[ADDR_W-1:OFS_W]));

    // R6: wait cycle keeps the address unless the mode pin moved
    a_r6_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && adv_n_i) |=> ($stable(addr_o) || !$stable(ilv_mode_i)));

    // R4: linear advance adds one modulo four
    a_r4_linear_step: assert property (@(posedge clk) disable iff (rst)
        (!load && !adv_n_i && !ilv_mode_i) |=>
            (ilv_mode_i || addr_o[OFS_W-1:0] == ofs_t'($past(addr_o[OFS_W-1:0]) + 1'b1)));

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int ADDR_W = 16;
    localparam int WDOG   = 200000;

    typedef struct packed {
        logic              ld_a;
        logic              ld_b;
        logic              adv_n;
        logic              mode;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] expv;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 27;

    // fields: ld_a, ld_b, adv_n, mode, addr_i, expected addr_o, requirement
    localparam vec_t TBL [NV] = '{
        // R2 load via first strobe, linear start 01
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'hABC1, 16'hABC1, 4'd2},
        // R4 linear 01 -> 10 -> 11 -> 00
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hABC2, 4'd4},
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hABC3, 4'd4},
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hABC0, 4'd4},
        // R7 wrap back to start
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hABC1, 4'd7},
        // R6 wait cycle
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'hABC1, 4'd6},
        // R3 address input changes without a strobe
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h1234, 16'hABC1, 4'd3},
        // R3 advance with changing input: upper bits kept
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'hABC2, 4'd3},
        // R2 load via second strobe, interleaved start 10
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'h5552, 16'h5552, 4'd2},
        // R5 interleaved 10 -> 11 -> 00 -> 01
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h5553, 4'd5},
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h5553, 4'd6},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h5550, 4'd5},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h5551, 4'd5},
        // R7 interleaved wrap
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h5552, 4'd7},
        // R5 interleaved start 11: 11 -> 10 -> 01 -> 00
        '{1'b1, 1'b0, 1'b1, 1'b1, 16'h0F03, 16'h0F03, 4'd5},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0F02, 4'd5},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0F01, 4'd5},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h0F00, 4'd5},
        // R8 strobe and advance together: load wins
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'h7771, 16'h7771, 4'd8},
        // R5 interleaved 01 -> 00
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h7770, 4'd5},
        // R9 mode flips to linear: start 01 count 1 -> 10
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h7772, 4'd9},
        // R9 back to interleaved -> 00
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h7770, 4'd9},
        // R8 second strobe with advance
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'h0002, 16'h0002, 4'd8},
        // R4 linear 10 -> 11 -> 00 -> 01
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0003, 4'd4},
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 4'd4},
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0001, 4'd4},
        // R2 reload mid-burst
        '{1'b1, 1'b1, 1'b1, 1'b0, 16'hC0DE, 16'hC0DE, 4'd2}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              ld_a_i;
    logic              ld_b_i;
    logic              adv_n_i;
    logic              ilv_mode_i;
    logic [ADDR_W-1:0] addr_i;
    logic [ADDR_W-1:0] addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .ld_a_i     (ld_a_i),
        .ld_b_i     (ld_b_i),
        .adv_n_i    (adv_n_i),
        .ilv_mode_i (ilv_mode_i),
        .addr_i     (addr_i),
        .addr_o     (addr_o)
    );

    task automatic check(input int req, input logic [ADDR_W-1:0] expv);
        n_checks++;
        if (addr_o !== expv) begin
            n_fail++;
            $display("FAIL R%0d: addr_o=%h expected=%h", req, addr_o, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > WDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WDOG);
            finish_run();
        end
    end

    initial begin
        rst        = 1'b1;
        ld_a_i     = 1'b0;
        ld_b_i     = 1'b0;
        adv_n_i    = 1'b1;
        ilv_mode_i = 1'b0;
        addr_i     = 16'hFFFF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(1, 16'h0000); // R1 reset state
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            ld_a_i     = TBL[i].ld_a;
            ld_b_i     = TBL[i].ld_b;
            adv_n_i    = TBL[i].adv_n;
            ilv_mode_i = TBL[i].mode;
            addr_i     = TBL[i].addr;
            @(posedge clk);
            @(negedge clk);
            check(int'(TBL[i].req), TBL[i].expv);
        end

        // R1 reset in the middle of a burst
        ld_a_i = 1'b0; ld_b_i = 1'b0; adv_n_i = 1'b0; ilv_mode_i = 1'b0;
        @(posedge clk); @(negedge clk);
        check(4, 16'hC0DF);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(1, 16'h0000); // R1
        rst = 1'b0; adv_n_i = 1'b0;
        @(posedge clk); @(negedge clk);
        check(1, 16'h0001); // R1 count restarted from zero
        adv_n_i = 1'b1;

        done = 1'b1;
        finish_run();
    end

endmodule